// File: doc/BRIEF.md
# Balanced-Ternary Bytecode Stack Core

This core runs a byte-wide bytecode program held in an external instruction memory. It works on a last-in, first-out stack of balanced-ternary digits (trits). Each trit is held as a two-bit code, and one of the four patterns is reserved as an illegal value. The core fetches one byte per cycle from the address it drives. The instruction memory must return that byte combinationally in the same cycle, so the fetch path has no valid/ready handshake and the memory can never apply back-pressure.

The core has three instructions: HALT, PUSH (push an immediate trit), and ternary ADD (replace the top two trits with their saturated sum). Any illegal trit code, stack misuse or unknown opcode raises a sticky fault and stops the core. The core has a data-memory port, but it is held idle. The status pins show the halted state, the fault, the current stack top and whether the stack is empty. They are plain levels with no handshake.

Top module: `tstack_core`

## Requirements
- R1: Trit codes are 2'b01 = -1, 2'b10 = +1 and 2'b11 = 0; 2'b00 is illegal. Opcode 8'h01 (PUSH) pushes the trit held in bits [1:0] of the byte that follows it, ignores bits [7:2] of that byte, and advances the program counter by 2.
- R2: Opcode 8'h00 (HALT) raises `halted`. After that the program counter and the stack stay frozen until reset.
- R3: Opcode 8'h02 (ADD) replaces the top two stack entries with their sum, so the stack shrinks by one. It advances the program counter by 1.
- R4: When an ADD result lies outside -1..+1, it saturates to -1 or +1.
- R5: ADD with fewer than two entries on the stack raises the fault and leaves the stack unchanged.
- R6: Any opcode from 8'h03 to 8'hFF raises the fault.
- R7: A PUSH whose operand byte has bits [1:0] = 2'b00 raises the fault and pushes nothing.
- R8: A PUSH while the stack holds DEPTH (default 256) entries raises the fault and pushes nothing.
- R9: The fault is sticky and forces `halted`. The program counter stays at the address of the byte that caused the fault.
- R10: When the stack is empty, `stack_empty` is 1 and `stack_top` reads 2'b11.
- R11: Reset sets the program counter to 0, clears `halted` and `fault`, and empties the stack.
- R12: The data-memory port stays idle: both enables are 0, the address is 0, and the write data is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Program counter / fetch address |
| imem_data | input | 8 | Byte at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 16 | Data-memory address (held at 0) |
| dmem_wdata | output | 2 | Data-memory write trit (held at 2'b11) |
| dmem_we | output | 1 | Data-memory write enable (held at 0) |
| dmem_re | output | 1 | Data-memory read enable (held at 0) |
| dmem_rdata | input | 2 | Data-memory read trit (unused) |
| halted | output | 1 | Core stopped by HALT or by a fault |
| fault | output | 1 | Sticky fault flag |
| stack_top | output | 2 | Trit on top of the stack |
| stack_empty | output | 1 | Stack holds no entries |

## Verification
The assertions take for granted that `imem_data` always carries a defined byte for the current address within the same cycle, since the core decodes it combinationally. They also take for granted that reset is asserted before the first edge. The bench meets both conditions. It serves every fetch from a combinational byte array, and every address past the loaded program returns 8'h00, so a program can never run off into undefined data. It holds reset low for two full cycles before each program starts.

// File: rtl/tstack_pkg.sv
package tstack_pkg;
  localparam logic [1:0] TR_BAD  = 2'b00;
  localparam logic [1:0] TR_NEG  = 2'b01;
  localparam logic [1:0] TR_POS  = 2'b10;
  localparam logic [1:0] TR_ZERO = 2'b11;

  localparam logic [7:0] OP_HALT = 8'h00;
  localparam logic [7:0] OP_PUSH = 8'h01;
  localparam logic [7:0] OP_ADD  = 8'h02;

  typedef enum logic [1:0] {ST_FETCH, ST_OPND, ST_STOP} core_st_e;

  function automatic logic signed [2:0] trit_val(input logic [1:0] t);
    case (t)
      TR_NEG:  trit_val = -3'sd1;
      TR_POS:  trit_val = 3'sd1;
      default: trit_val = 3'sd0;
    endcase
  endfunction

  function automatic logic [1:0] trit_sat_add(input logic [1:0] a, input logic [1:0] b);
    logic signed [2:0] s;
    s = trit_val(a) + trit_val(b);
    if (s > 3'sd0)      trit_sat_add = TR_POS;
    else if (s < 3'sd0) trit_sat_add = TR_NEG;
    else                trit_sat_add = TR_ZERO;
  endfunction
endpackage

// File: rtl/tstack_alu.sv
module tstack_alu
  import tstack_pkg::*;
(
  input  logic [1:0] op_a,
  input  logic [1:0] op_b,
  output logic [1:0] sum,
  output logic       bad
);
  always_comb begin
    sum = trit_sat_add(op_a, op_b);
    bad = (op_a == TR_BAD) || (op_b == TR_BAD);
  end
endmodule

// File: rtl/tstack_lifo.sv
module tstack_lifo
  import tstack_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          fold_en,
  input  logic [1:0]    wdata,
  output logic [1:0]    top,
  output logic [1:0]    below,
  output logic [CW-1:0] count
);
  logic [1:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] i_top, i_below, i_free;

  always_comb begin
    i_top   = AW'(cnt - CW'(1));
    i_below = AW'(cnt - CW'(2));
    i_free  = AW'(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= TR_ZERO;
    end else if (push_en && !fold_en) begin
      if (cnt < CW'(DEPTH)) begin
        mem[i_free] <= wdata;
        cnt         <= cnt + CW'(1);
      end
    end else if (fold_en && !push_en) begin
      if (cnt >= CW'(2)) begin
        mem[i_below] <= wdata;
        cnt          <= cnt - CW'(1);
      end
    end
  end

  always_comb begin
    top   = (cnt != '0)      ? mem[i_top]   : TR_ZERO;
    below = (cnt >= CW'(2))  ? mem[i_below] : TR_ZERO;
    count = cnt;
  end
endmodule

// File: rtl/tstack_ctrl.sv
module tstack_ctrl
  import tstack_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PCW = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    op,
  input  logic [CW-1:0] count,
  input  logic          add_bad,
  output logic [PCW-1:0] pc,
  output logic          push_en,
  output logic          fold_en,
  output logic [1:0]    push_trit,
  output logic          halted,
  output logic          fault
);
  core_st_e       st, st_n;
  logic [PCW-1:0] pc_n;
  logic           trap;

  always_comb begin
    st_n    = st;
    pc_n    = pc;
    push_en = 1'b0;
    fold_en = 1'b0;
    trap    = 1'b0;
    case (st)
      ST_FETCH: begin
        case (op)
          OP_HALT: st_n = ST_STOP;
          OP_PUSH: begin
            st_n = ST_OPND;
            pc_n = pc + PCW'(1);
          end
          OP_ADD: begin
            if (count < CW'(2) || add_bad) trap = 1'b1;
            else begin
              fold_en = 1'b1;
              pc_n    = pc + PCW'(1);
            end
          end
          default: trap = 1'b1;
        endcase
      end
      ST_OPND: begin
        if (op[1:0] == TR_BAD || count == CW'(DEPTH)) trap = 1'b1;
        else begin
          push_en = 1'b1;
          pc_n    = pc + PCW'(1);
          st_n    = ST_FETCH;
        end
      end
      default: ;
    endcase
    if (trap) begin
      st_n    = ST_STOP;
      pc_n    = pc;
      push_en = 1'b0;
      fold_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FETCH;
      pc    <= '0;
      fault <= 1'b0;
    end else begin
      st    <= st_n;
      pc    <= pc_n;
      fault <= fault | trap;
    end
  end

  always_comb begin
    halted    = (st == ST_STOP);
    push_trit = op[1:0];
  end
endmodule

// File: rtl/tstack_core.sv
module tstack_core
  import tstack_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [7:0]    imem_data,
  output logic [AW-1:0] dmem_addr,
  output logic [1:0]    dmem_wdata,
  output logic          dmem_we,
  output logic          dmem_re,
  input  logic [1:0]    dmem_rdata,
  output logic          halted,
  output logic          fault,
  output logic [1:0]    stack_top,
  output logic          stack_empty
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] count;
  logic [1:0]    below, sum, push_trit, wdata;
  logic          add_bad, push_en, fold_en;

  tstack_ctrl #(.DEPTH(DEPTH), .PCW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(imem_data), .count(count), .add_bad(add_bad),
    .pc(imem_addr), .push_en(push_en), .fold_en(fold_en), .push_trit(push_trit),
    .halted(halted), .fault(fault)
  );

  tstack_alu u_alu (.op_a(stack_top), .op_b(below), .sum(sum), .bad(add_bad));

  assign wdata = push_en ? push_trit : sum;

  tstack_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .fold_en(fold_en), .wdata(wdata),
    .top(stack_top), .below(below), .count(count)
  );

  always_comb begin
    stack_empty = (count == '0);
    dmem_addr   = '0;
    dmem_wdata  = TR_ZERO;
    dmem_we     = 1'b0;
    dmem_re     = (dmem_rdata == TR_BAD) & 1'b0;
  end
endmodule

// File: rtl/tstack_chk.sv
module tstack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] imem_addr,
  input logic [15:0] dmem_addr,
  input logic        dmem_we,
  input logic        dmem_re,
  input logic        halted,
  input logic        fault,
  input logic [1:0]  stack_top,
  input logic        stack_empty
);
  p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(imem_addr));
  p_fault_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);
  p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_empty |-> stack_top == 2'b11);
  p_top_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stack_top != 2'b00);
  p_dmem_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dmem_we && !dmem_re && dmem_addr == 16'h0);
  p_pc_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> imem_addr >= $past(imem_addr));
endmodule

bind tstack_core tstack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_addr(dmem_addr),
  .dmem_we(dmem_we), .dmem_re(dmem_re), .halted(halted), .fault(fault),
  .stack_top(stack_top), .stack_empty(stack_empty)
);

// File: tb/tstack_core_bench.sv
`timescale 1ns/1ps
module tstack_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, dmem_addr;
  logic [7:0]  imem_data;
  logic [1:0]  dmem_wdata, stack_top;
  logic        dmem_we, dmem_re, halted, fault, stack_empty;
  logic [7:0]  rom [1024];
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  assign imem_data = (imem_addr < 16'd1024) ? rom[imem_addr[9:0]] : 8'h00;

  tstack_core u_tstack_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(2'b11), .halted(halted), .fault(fault),
    .stack_top(stack_top), .stack_empty(stack_empty)
  );

  typedef struct packed {
    logic [63:0] prog;
    logic [15:0] pc;
    logic        hlt;
    logic        flt;
    logic [1:0]  top;
    logic        emp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{64'h0000000000000201, 16'd2, 1'b1, 1'b0, 2'b10, 1'b0}, // R1 push +1
    '{64'h0000000201010201, 16'd5, 1'b1, 1'b0, 2'b11, 1'b0}, // R3 +1 + -1
    '{64'h0000000202010201, 16'd5, 1'b1, 1'b0, 2'b10, 1'b0}, // R4 sat +1
    '{64'h0000000201010101, 16'd5, 1'b1, 1'b0, 2'b01, 1'b0}, // R4 sat -1
    '{64'h0000000000000000, 16'd0, 1'b1, 1'b0, 2'b11, 1'b1}, // R2 R10 halt
    '{64'h0000000000000002, 16'd0, 1'b1, 1'b1, 2'b11, 1'b1}, // R5 empty add
    '{64'h0000000000020201, 16'd2, 1'b1, 1'b1, 2'b10, 1'b0}, // R5 one entry
    '{64'h0000000000000007, 16'd0, 1'b1, 1'b1, 2'b11, 1'b1}, // R6 bad opcode
    '{64'h0000000000000001, 16'd1, 1'b1, 1'b1, 2'b11, 1'b1}, // R7 bad operand
    '{64'h000000000000FE01, 16'd2, 1'b1, 1'b0, 2'b10, 1'b0}, // R1 upper bits
    '{64'h0000000201010301, 16'd5, 1'b1, 1'b0, 2'b01, 1'b0}, // R3 0 + -1
    '{64'h0000000202010101, 16'd5, 1'b1, 1'b0, 2'b11, 1'b0}  // R3 -1 + +1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = 8'h00;
  endtask

  task automatic restart(input int cycles);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #1ms;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] pc_snap;
    clear_rom();
    rom[0] = 8'h01; rom[1] = 8'h02;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 pc", imem_addr, 0);
    chk("R11 halted", halted, 0);
    chk("R11 fault", fault, 0);
    chk("R10 empty", stack_empty, 1);
    chk("R10 top", stack_top, 2'b11);

    for (int v = 0; v < NV; v++) begin
      clear_rom();
      for (int b = 0; b < 8; b++) rom[b] = VECS[v].prog[b*8 +: 8];
      restart(30);
      chk($sformatf("R9 pc v%0d", v), imem_addr, VECS[v].pc);
      chk($sformatf("R2 halted v%0d", v), halted, VECS[v].hlt);
      chk($sformatf("R9 fault v%0d", v), fault, VECS[v].flt);
      chk($sformatf("R4 top v%0d", v), stack_top, VECS[v].top);
      chk($sformatf("R10 empty v%0d", v), stack_empty, VECS[v].emp);
      chk($sformatf("R12 dmem v%0d", v), {dmem_we, dmem_re, dmem_addr, dmem_wdata},
          {2'b00, 16'h0, 2'b11});
      pc_snap = imem_addr;
      repeat (5) @(negedge clk);
      chk($sformatf("R2 pc frozen v%0d", v), imem_addr, pc_snap);
    end

    // R8 overflow: 257 pushes of +1
    clear_rom();
    for (int i = 0; i < 257; i++) begin
      rom[2*i] = 8'h01; rom[2*i+1] = 8'h02;
    end
    restart(600);
    chk("R8 fault", fault, 1);
    chk("R8 halted", halted, 1);
    chk("R8 pc", imem_addr, 513);
    chk("R8 top", stack_top, 2'b10);
    chk("R8 empty", stack_empty, 0);

    // R11 reset clears fault
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 fault clear", fault, 0);
    chk("R11 halted clear", halted, 0);
    chk("R11 pc clear", imem_addr, 0);
    chk("R11 empty", stack_empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule